// File: doc/BRIEF.md
# CSR Instruction Access Controller

This block executes the six control-and-status-register instructions: write, set and clear, each with either a register operand or a 5-bit immediate operand. From the function code and from whether the destination index, the source index or the immediate is zero, it decides two things separately: whether the CSR is read and whether it is written. The read and write strobes therefore fire exactly when the instruction requires them. Every read or write side effect is either suppressed or forced on that basis. The block also computes the new CSR value and returns the old value for the destination register. It raises an illegal-instruction trap when a write targets a read-only CSR, or when either access would touch an address that is not implemented.

A small demonstration CSR file sits inside the block so that side effects can be seen at the ports. It holds three registers:

- A scratch register that can be read and written (address 0x0C0).
- A constant read-only register (address 0xC00).
- An access-count register (address 0x0C1). It counts its own read strobes and write strobes.

An instruction is presented for one cycle with `exec_valid`. The strobes and write data appear in that same cycle. The result appears in the following cycle.

A two-state retire machine sequences the result:

- ST_IDLE moves to ST_RETIRE on the transition EXEC_START, which fires when `exec_valid` is high.
- ST_RETIRE stays in ST_RETIRE on BACK_TO_BACK, which fires when another instruction arrives.
- ST_RETIRE returns to ST_IDLE on RETIRE_END otherwise.

Top module: `csr_exec_unit`

## Requirements
- R1: `func_code` selects the operation. 001 is write, 010 is set and 011 is clear, each with a register operand. 101, 110 and 111 are the same three operations with an immediate operand. Codes 000 and 100 assert neither strobe, raise no trap and do not write rd. No strobe is asserted while `exec_valid` is low.
- R2: The write forms always assert the write strobe. They assert the read strobe only when `rd_idx` is nonzero. The register write form with `src_idx` 0 writes the value zero, whatever `src_val` holds.
- R3: The register set and clear forms do not write when `src_idx` is 0. When `src_idx` is nonzero they write, even if `src_val` is zero; in that case the unchanged value is written back.
- R4: All set and clear forms, register and immediate, assert the read strobe whatever `rd_idx` and `src_idx` are.
- R5: The immediate set and clear forms write only when the 5-bit immediate (`src_idx`) is nonzero. Immediate forms use that field zero-extended to XLEN bits as the operand.
- R6: The write data is as follows. Write gives the operand. Set gives old OR operand. Clear gives old AND NOT operand.
- R7: A CSR whose address bits [11:10] are 11 is read-only. An instruction that would write it raises `trap`, asserts neither strobe and leaves `rd_we` low. Reading it without a write is legal and returns the constant RO_VALUE (0x1234ABCD by default).
- R8: Any access to an address other than 0x0C0, 0x0C1 or 0xC00 raises `trap` and asserts no strobe, provided either strobe would have been asserted.
- R9: The strobes and `csr_wr_data` are combinational in the cycle of `exec_valid`. One cycle later:
  - `done` pulses.
  - `trap` is valid.
  - `rd_we` is high when the read strobe fired and `rd_idx` is nonzero.
  - `rd_data` holds the CSR value from before the write when the read strobe fired, and 0 otherwise.
- R10: The access-count CSR reads as the read count in bits [31:16] and the write count in bits [15:0]. Each count increments once per asserted strobe to that address. Write data is discarded, and a read returns the value from before the increment.
- R11: After reset, the scratch register and both counts are zero, and `done`, `rd_we` and `trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_valid | input | 1 | One-cycle instruction valid |
| func_code | input | 3 | Decoded CSR function code |
| rd_idx | input | 5 | Destination register index |
| src_idx | input | 5 | Source register index or 5-bit immediate |
| src_val | input | XLEN | Source register value |
| csr_addr | input | 12 | CSR address |
| csr_rd_stb | output | 1 | CSR read strobe |
| csr_wr_stb | output | 1 | CSR write strobe |
| csr_wr_data | output | XLEN | New CSR value |
| done | output | 1 | Retire pulse, one cycle after `exec_valid` |
| rd_we | output | 1 | Destination register write enable |
| rd_data | output | XLEN | Old CSR value for rd |
| trap | output | 1 | Illegal-instruction flag |

## Verification
The assertions check the following every cycle:
- No strobe fires outside `exec_valid`.
- No write strobe reaches a read-only address.
- The write form with rd x0 never reads.
- Set and clear with a zero source field never write, and every set or clear write also reads.
- `done` follows `exec_valid` by exactly one cycle.
- A trap never coincides with `rd_we`.

Only the bench scenarios can show the rest. That covers the arithmetic of the new value, the old value returned, and the zero-extension of the immediate. It also covers the count CSR advancing by exactly one per strobe, which a bench model tracks across long random sequences and directed corners such as a nonzero register that holds zero.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RETIRE = 1'b1
    } retire_state_e;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned IDX_W  = 5;

    localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 12'h0C0;
    localparam logic [ADDR_W-1:0] ADDR_COUNT   = 12'h0C1;
    localparam logic [ADDR_W-1:0] ADDR_CONST   = 12'hC00;

endpackage

// File: rtl/csr_access_decode.sv
module csr_access_decode
    import csr_exec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              exec_valid,
    input  logic [2:0]        func_code,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [XLEN-1:0]   src_val,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              addr_hit,
    input  logic [XLEN-1:0]   old_val,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [XLEN-1:0]   wr_data,
    output logic              trap_now
);

    csr_op_e         op;
    logic            use_imm;
    logic            want_rd;
    logic            want_wr;
    logic            read_only;
    logic [XLEN-1:0] operand;

    assign op        = csr_op_e'(func_code[1:0]);
    assign use_imm   = func_code[2];
    assign read_only = (csr_addr[ADDR_W-1 -: 2] == 2'b11);

    always_comb begin
        if (use_imm) begin
            operand = {{(XLEN-IDX_W){1'b0}}, src_idx};
        end else if (src_idx == '0) begin
            operand = '0;
        end else begin
            operand = src_val;
        end
    end

    always_comb begin
        want_rd = 1'b0;
        want_wr = 1'b0;
        wr_data = old_val;
        unique case (op)
            OP_NONE: begin
                want_rd = 1'b0;
                want_wr = 1'b0;
            end
            OP_WRITE: begin
                want_rd = (rd_idx != '0);
                want_wr = 1'b1;
                wr_data = operand;
            end
            OP_SET: begin
                want_rd = 1'b1;
                want_wr = (src_idx != '0);
                wr_data = old_val | operand;
            end
            OP_CLEAR: begin
                want_rd = 1'b1;
                want_wr = (src_idx != '0);
                wr_data = old_val & ~operand;
            end
            default: begin
                want_rd = 1'b0;
                want_wr = 1'b0;
            end
        endcase
    end

    assign trap_now = exec_valid && (want_rd || want_wr) &&
                      (!addr_hit || (want_wr && read_only));
    assign rd_stb   = exec_valid && want_rd && !trap_now;
    assign wr_stb   = exec_valid && want_wr && !trap_now;

endmodule

// File: rtl/csr_demo_file.sv
module csr_demo_file
    import csr_exec_pkg::*;
#(
    parameter int unsigned  XLEN     = 32,
    parameter logic [XLEN-1:0] RO_VALUE = 32'h1234ABCD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [XLEN-1:0]   wr_data,
    output logic              addr_hit,
    output logic [XLEN-1:0]   old_val
);

    localparam int unsigned CNT_W = XLEN / 2;

    logic [XLEN-1:0]  scratch_q;
    logic [CNT_W-1:0] rd_count_q;
    logic [CNT_W-1:0] wr_count_q;

    always_comb begin
        addr_hit = 1'b1;
        unique case (csr_addr)
            ADDR_SCRATCH: old_val = scratch_q;
            ADDR_COUNT:   old_val = {rd_count_q, wr_count_q};
            ADDR_CONST:   old_val = RO_VALUE;
            default: begin
                addr_hit = 1'b0;
                old_val  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q  <= '0;
            rd_count_q <= '0;
            wr_count_q <= '0;
        end else begin
            if (wr_stb && csr_addr == ADDR_SCRATCH) begin
                scratch_q <= wr_data;
            end
            if (rd_stb && csr_addr == ADDR_COUNT) begin
                rd_count_q <= rd_count_q + 1'b1;
            end
            if (wr_stb && csr_addr == ADDR_COUNT) begin
                wr_count_q <= wr_count_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/csr_retire_fsm.sv
module csr_retire_fsm
    import csr_exec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_valid,
    input  logic             rd_stb,
    input  logic             trap_now,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [XLEN-1:0]  old_val,
    output logic             done,
    output logic             rd_we,
    output logic [XLEN-1:0]  rd_data,
    output logic             trap
);

    retire_state_e state_q;
    retire_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = exec_valid ? ST_RETIRE : ST_IDLE;
            ST_RETIRE: state_d = exec_valid ? ST_RETIRE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_we   <= 1'b0;
            rd_data <= '0;
            trap    <= 1'b0;
        end else if (exec_valid) begin
            rd_we   <= rd_stb && (rd_idx != '0);
            rd_data <= rd_stb ? old_val : '0;
            trap    <= trap_now;
        end else begin
            rd_we   <= 1'b0;
            rd_data <= '0;
            trap    <= 1'b0;
        end
    end

    assign done = (state_q == ST_RETIRE);

endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
    import csr_exec_pkg::*;
#(
    parameter int unsigned     XLEN     = 32,
    parameter logic [XLEN-1:0] RO_VALUE = 32'h1234ABCD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_valid,
    input  logic [2:0]        func_code,
    input  logic [4:0]        rd_idx,
    input  logic [4:0]        src_idx,
    input  logic [XLEN-1:0]   src_val,
    input  logic [11:0]       csr_addr,
    output logic              csr_rd_stb,
    output logic              csr_wr_stb,
    output logic [XLEN-1:0]   csr_wr_data,
    output logic              done,
    output logic              rd_we,
    output logic [XLEN-1:0]   rd_data,
    output logic              trap
);

    logic            addr_hit;
    logic [XLEN-1:0] old_val;
    logic            trap_now;

    csr_access_decode #(.XLEN(XLEN)) u_decode (
        .exec_valid (exec_valid),
        .func_code  (func_code),
        .rd_idx     (rd_idx),
        .src_idx    (src_idx),
        .src_val    (src_val),
        .csr_addr   (csr_addr),
        .addr_hit   (addr_hit),
        .old_val    (old_val),
        .rd_stb     (csr_rd_stb),
        .wr_stb     (csr_wr_stb),
        .wr_data    (csr_wr_data),
        .trap_now   (trap_now)
    );

    csr_demo_file #(.XLEN(XLEN), .RO_VALUE(RO_VALUE)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_addr (csr_addr),
        .rd_stb   (csr_rd_stb),
        .wr_stb   (csr_wr_stb),
        .wr_data  (csr_wr_data),
        .addr_hit (addr_hit),
        .old_val  (old_val)
    );

    csr_retire_fsm #(.XLEN(XLEN)) u_retire (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_valid (exec_valid),
        .rd_stb     (csr_rd_stb),
        .trap_now   (trap_now),
        .rd_idx     (rd_idx),
        .old_val    (old_val),
        .done       (done),
        .rd_we      (rd_we),
        .rd_data    (rd_data),
        .trap       (trap)
    );

endmodule

// File: rtl/csr_exec_chk.sv
module csr_exec_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exec_valid,
    input logic [2:0]      func_code,
    input logic [4:0]      rd_idx,
    input logic [4:0]      src_idx,
    input logic [11:0]     csr_addr,
    input logic            csr_rd_stb,
    input logic            csr_wr_stb,
    input logic            done,
    input logic            rd_we,
    input logic            trap
);

    // R1
    no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |-> (!csr_rd_stb && !csr_wr_stb));

    // R7
    no_ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_stb |-> (csr_addr[11:10] != 2'b11));

    // R2
    write_rd0_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && func_code[1:0] == 2'b01 && rd_idx == 5'd0) |-> !csr_rd_stb);

    // R3
    setclr_zero_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && func_code[1] && src_idx == 5'd0) |-> !csr_wr_stb);

    // R4
    setclr_write_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_stb && func_code[1]) |-> csr_rd_stb);

    // R9
    retire_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> done);

    // R9
    retire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> !done);

    // R7
    trap_no_rdwe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !rd_we);

endmodule

bind csr_exec_unit csr_exec_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_valid (exec_valid),
    .func_code  (func_code),
    .rd_idx     (rd_idx),
    .src_idx    (src_idx),
    .csr_addr   (csr_addr),
    .csr_rd_stb (csr_rd_stb),
    .csr_wr_stb (csr_wr_stb),
    .done       (done),
    .rd_we      (rd_we),
    .trap       (trap)
);

// File: tb/tb_csr_exec_unit.sv
`timescale 1ns/1ps
module tb_csr_exec_unit;

    localparam int unsigned XLEN = 32;
    localparam logic [31:0] RO_VAL = 32'h1234ABCD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_valid = 1'b0;
    logic [2:0]  func_code = '0;
    logic [4:0]  rd_idx = '0;
    logic [4:0]  src_idx = '0;
    logic [31:0] src_val = '0;
    logic [11:0] csr_addr = '0;
    logic        csr_rd_stb, csr_wr_stb, done, rd_we, trap;
    logic [31:0] csr_wr_data, rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_scratch = '0;
    logic [15:0] m_rcnt = '0;
    logic [15:0] m_wcnt = '0;

    always #2 clk = ~clk;

    csr_exec_unit #(.XLEN(XLEN), .RO_VALUE(RO_VAL)) dut (
        .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .func_code(func_code),
        .rd_idx(rd_idx), .src_idx(src_idx), .src_val(src_val), .csr_addr(csr_addr),
        .csr_rd_stb(csr_rd_stb), .csr_wr_stb(csr_wr_stb), .csr_wr_data(csr_wr_data),
        .done(done), .rd_we(rd_we), .rd_data(rd_data), .trap(trap)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] old_of(input logic [11:0] a);
        case (a)
            12'h0C0: return m_scratch;
            12'h0C1: return {m_rcnt, m_wcnt};
            12'hC00: return RO_VAL;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit implemented(input logic [11:0] a);
        return (a == 12'h0C0) || (a == 12'h0C1) || (a == 12'hC00);
    endfunction

    task automatic run_op(input logic [2:0] f, input logic [4:0] rd, input logic [4:0] src,
                          input logic [31:0] val, input logic [11:0] a,
                          output logic [31:0] got);
        logic [1:0]  kind;
        bit          e_rd, e_wr, e_trap;
        logic [31:0] opnd, oldv, e_data;
        kind = f[1:0];
        e_rd = (kind != 2'b00) && (kind != 2'b01 || rd != 0);
        e_wr = (kind != 2'b00) && (kind == 2'b01 || src != 0);
        opnd = f[2] ? {27'd0, src} : (src == 0 ? 32'd0 : val);
        oldv = old_of(a);
        e_data = (kind == 2'b01) ? opnd : (kind == 2'b10) ? (oldv | opnd) : (oldv & ~opnd);
        e_trap = (e_rd || e_wr) && (!implemented(a) || (e_wr && a[11:10] == 2'b11));
        if (e_trap) begin
            e_rd = 0;
            e_wr = 0;
        end
        @(negedge clk);
        exec_valid = 1'b1; func_code = f; rd_idx = rd; src_idx = src; src_val = val; csr_addr = a;
        #1;
        chk("R1 R2 R3 R4 R5 R8 read strobe", {31'd0, csr_rd_stb}, {31'd0, e_rd});
        chk("R1 R2 R3 R5 R7 R8 write strobe", {31'd0, csr_wr_stb}, {31'd0, e_wr});
        if (e_wr) chk("R6 write data", csr_wr_data, e_data);
        @(negedge clk);
        exec_valid = 1'b0;
        chk("R9 done pulse", {31'd0, done}, 32'd1);
        chk("R7 R8 trap", {31'd0, trap}, {31'd0, e_trap});
        chk("R9 rd_we", {31'd0, rd_we}, {31'd0, (e_rd && rd != 0)});
        chk("R9 rd_data old value", rd_data, e_rd ? oldv : 32'd0);
        got = rd_data;
        if (e_wr && a == 12'h0C0) m_scratch = e_data;
        if (e_wr && a == 12'h0C1) m_wcnt = m_wcnt + 1'b1;
        if (e_rd && a == 12'h0C1) m_rcnt = m_rcnt + 1'b1;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic [11:0] addrs [5];
        void'($urandom(32'd2024));
        addrs[0] = 12'h0C0; addrs[1] = 12'h0C1; addrs[2] = 12'hC00;
        addrs[3] = 12'h0C7; addrs[4] = 12'hC05;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 done at reset", {31'd0, done}, 32'd0);
        chk("R11 rd_we at reset", {31'd0, rd_we}, 32'd0);
        chk("R11 trap at reset", {31'd0, trap}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle no read strobe", {31'd0, csr_rd_stb}, 32'd0);
        // R11 / R10 counter and scratch start at zero
        run_op(3'b010, 5'd1, 5'd0, 32'hFFFF_FFFF, 12'h0C1, got);
        chk("R11 R10 counter zero after reset", got, 32'd0);
        run_op(3'b010, 5'd1, 5'd0, 32'h0, 12'h0C0, got);
        chk("R11 scratch zero after reset", got, 32'd0);
        // R2 write with rs1 x0 writes zero despite src_val
        run_op(3'b001, 5'd0, 5'd3, 32'hA5A5_0F0F, 12'h0C0, got);
        run_op(3'b001, 5'd2, 5'd0, 32'hDEAD_BEEF, 12'h0C0, got);
        chk("R2 prior value returned", got, 32'hA5A5_0F0F);
        run_op(3'b010, 5'd2, 5'd0, 32'h0, 12'h0C0, got);
        chk("R2 x0 wrote zero", got, 32'd0);
        // R10 write with rd x0 to counter: write count only
        run_op(3'b001, 5'd0, 5'd4, 32'h1234, 12'h0C1, got);
        run_op(3'b010, 5'd5, 5'd0, 32'h0, 12'h0C1, got);
        chk("R10 counter after write rd0", got, 32'h0001_0001);
        // R3 nonzero register holding zero still writes
        run_op(3'b011, 5'd0, 5'd6, 32'h0, 12'h0C1, got);
        run_op(3'b011, 5'd7, 5'd0, 32'h0, 12'h0C1, got);
        chk("R3 zero-valued set/clear still wrote", got, 32'h0003_0002);
        // R5 immediate zero-extension
        run_op(3'b101, 5'd0, 5'd31, 32'hFFFF_FFFF, 12'h0C0, got);
        run_op(3'b110, 5'd1, 5'd0, 32'h0, 12'h0C0, got);
        chk("R5 imm zero-extended", got, 32'h0000_001F);
        // R7 read-only: read legal, write traps, csrrs x0 no trap
        run_op(3'b010, 5'd1, 5'd0, 32'h0, 12'hC00, got);
        chk("R7 read-only value", got, RO_VAL);
        run_op(3'b110, 5'd1, 5'd1, 32'h0, 12'hC00, got);
        run_op(3'b001, 5'd1, 5'd0, 32'h0, 12'hC00, got);
        // R8 unimplemented, and R1 invalid code on bad address no trap
        run_op(3'b011, 5'd1, 5'd0, 32'h0, 12'h0C7, got);
        run_op(3'b100, 5'd1, 5'd1, 32'h0, 12'h0C7, got);
        run_op(3'b000, 5'd1, 5'd1, 32'h5, 12'h0C0, got);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [4:0]  r_rd, r_src;
            logic [31:0] r_val;
            r_rd  = ($urandom % 2) ? 5'd0 : 5'($urandom);
            r_src = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
            r_val = ($urandom % 4 == 0) ? 32'd0 : $urandom;
            run_op(3'($urandom), r_rd, r_src, r_val, addrs[$urandom % 5], got);
        end
        @(negedge clk);
        chk("R9 done falls when idle", {31'd0, done}, 32'd0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule